// File: doc/BRIEF.md
# Boundary-Scan Instruction Decoder and Data-Register Selector

This block sits beside a test access port state machine and an instruction-register shifter. It latches the instruction the shifter presents on each Update-IR strobe, decodes it, and decides which data register forms the serial path from the test data input to the test data output. There are three candidates: a one-bit bypass register, a 32-bit identification register, and an external boundary scan chain whose serial output is fed back into this block.

The bypass register and the identification register are both inside this block, including their capture and shift behaviour. The identification register serves two instructions. One of them captures a fixed code built from parameters. The other captures a code supplied on an input port, which software can set.

The decoded instruction also drives pin-mode controls for the boundary cells: normal operation, external test, internal test, clamp, and high impedance. The test data output comes from a register that changes on the falling test clock edge. Its enable is raised only while the state machine is in a shift state.

Top module: `scan_dr_selector`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) makes the active instruction IDCODE (opcode 4'b0010) when `HAS_ID` is 1, and BYPASS (4'b1111) otherwise. After reset, `pin_mode` reads 0 and `tdo_en` reads 0.
- R2: BYPASS (4'b1111) and every unassigned opcode (4'b0111 to 4'b1110) select the one-bit bypass register. On Capture-DR it loads 0. In Shift-DR it takes `tdi`. The first bit shifted out is 0, and each later output bit repeats `tdi` from one shift cycle earlier.
- R3: IDCODE (4'b0010) selects the identification register. On Capture-DR it loads {version[3:0], part[15:0], maker[10:0], 1'b1}, where bit 0 is always 1. The code leaves on `tdo` LSB first.
- R4: USERCODE (4'b0011) selects the same identification register, but on Capture-DR it loads the `user_code` port instead of the fixed code.
- R5: EXTEST (4'b0000), SAMPLE/PRELOAD (4'b0001) and INTEST (4'b0100) select the boundary chain. `bsr_capture` and `bsr_shift` follow `capture_dr` and `shift_dr` only while the chain is selected. During Shift-DR, `tdo` carries `bsr_so`.
- R6: `pin_mode` encodes the pin mode as follows: 0 normal, 1 external test (EXTEST), 2 internal test (INTEST), 3 clamp, 4 high-Z. All other instructions give 0. `core_from_bsr` is 1 only under INTEST.
- R7: CLAMP (4'b0101) sets `pin_from_bsr` to 1 and routes the serial path through the bypass register. `pin_from_bsr` is also 1 under EXTEST and 0 for every other instruction.
- R8: HIGHZ (4'b0110) sets `pin_hiz` to 1 with `pin_from_bsr` at 0, and routes the serial path through the bypass register. `pin_hiz` is 0 for every other instruction.
- R9: `tdo` and `tdo_en` are registered on the falling edge of `tck`. `tdo_en` is 1 only after a falling edge at which `shift_dr` or `shift_ir` was high. During Shift-IR, `tdo` carries `ir_so`.
- R10: The active instruction changes only on a clock edge with `update_ir` high. At all other edges, changes on `ir_new` have no effect on the outputs.
- R11: In Shift-DR the selected identification register shifts right by one bit per clock, taking `tdi` into bit 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous test-logic reset, active high |
| tdi | input | 1 | Serial test data in |
| ir_new | input | OPC_W | Instruction presented by the instruction shifter |
| update_ir | input | 1 | Update-IR strobe: latch `ir_new` |
| capture_dr | input | 1 | Capture-DR state strobe |
| shift_dr | input | 1 | Shift-DR state strobe |
| shift_ir | input | 1 | Shift-IR state strobe |
| ir_so | input | 1 | Serial output of the instruction shifter |
| bsr_so | input | 1 | Serial output of the boundary chain |
| user_code | input | 32 | User-programmable identification code |
| tdo | output | 1 | Serial test data out |
| tdo_en | output | 1 | Output enable for `tdo` |
| bsr_capture | output | 1 | Capture strobe to the boundary chain |
| bsr_shift | output | 1 | Shift strobe to the boundary chain |
| pin_mode | output | 3 | Encoded pin mode (see R6) |
| pin_from_bsr | output | 1 | Pins driven from the boundary update stage |
| core_from_bsr | output | 1 | Core inputs driven from the boundary update stage |
| pin_hiz | output | 1 | All component outputs in high impedance |

## Verification
Mode outputs and the boundary strobes respond combinationally to the active instruction. The active instruction changes at the rising edge that samples `update_ir`, so the bench reads these outputs in the same cycle in which it drops `update_ir`.

`tdo` shows a data-register bit at the falling edge inside each Shift-DR cycle. That bit is the one the register held before the rising edge that ends the cycle. The bench therefore drives inputs 2 ns after a rising edge and samples 3 ns before the next rising edge, after the falling edge has updated `tdo`.

For shift cycle i, the expected bit is:
- bit i of the captured code, for the identification register;
- `tdi` from cycle i-1, or 0 at i=0, for the bypass register;
- the `bsr_so` value driven in cycle i, for the boundary chain.

// File: rtl/scan_dr_pkg.sv
package scan_dr_pkg;

    localparam int OPC_W = 4;
    localparam int ID_W  = 32;

    localparam logic [OPC_W-1:0] OP_EXTEST   = 4'h0;
    localparam logic [OPC_W-1:0] OP_SAMPLE   = 4'h1;
    localparam logic [OPC_W-1:0] OP_IDCODE   = 4'h2;
    localparam logic [OPC_W-1:0] OP_USERCODE = 4'h3;
    localparam logic [OPC_W-1:0] OP_INTEST   = 4'h4;
    localparam logic [OPC_W-1:0] OP_CLAMP    = 4'h5;
    localparam logic [OPC_W-1:0] OP_HIGHZ    = 4'h6;
    localparam logic [OPC_W-1:0] OP_BYPASS   = 4'hF;

    typedef enum logic [1:0] {
        DR_BYPASS   = 2'd0,
        DR_IDENT    = 2'd1,
        DR_BOUNDARY = 2'd2
    } dr_sel_e;

    typedef enum logic [2:0] {
        MODE_NORMAL = 3'd0,
        MODE_EXTEST = 3'd1,
        MODE_INTEST = 3'd2,
        MODE_CLAMP  = 3'd3,
        MODE_HIGHZ  = 3'd4
    } pin_mode_e;

    typedef struct packed {
        dr_sel_e   sel;
        pin_mode_e mode;
        logic      user_id;
    } ctl_t;

    function automatic ctl_t decode_op(input logic [OPC_W-1:0] op, input bit has_id);
        ctl_t c;
        c.sel     = DR_BYPASS;
        c.mode    = MODE_NORMAL;
        c.user_id = 1'b0;
        case (op)
            OP_EXTEST: begin
                c.sel  = DR_BOUNDARY;
                c.mode = MODE_EXTEST;
            end
            OP_SAMPLE:   c.sel = DR_BOUNDARY;
            OP_IDCODE:   c.sel = has_id ? DR_IDENT : DR_BYPASS;
            OP_USERCODE: begin
                c.sel     = has_id ? DR_IDENT : DR_BYPASS;
                c.user_id = 1'b1;
            end
            OP_INTEST: begin
                c.sel  = DR_BOUNDARY;
                c.mode = MODE_INTEST;
            end
            OP_CLAMP:    c.mode = MODE_CLAMP;
            OP_HIGHZ:    c.mode = MODE_HIGHZ;
            default:     c.sel = DR_BYPASS;
        endcase
        return c;
    endfunction

    function automatic logic [ID_W-1:0] id_word(input logic [3:0] ver,
                                                 input logic [15:0] part,
                                                 input logic [10:0] maker);
        return {ver, part, maker, 1'b1};
    endfunction

endpackage

// File: rtl/scan_ir_decode.sv
module scan_ir_decode
    import scan_dr_pkg::*;
#(
    parameter bit HAS_ID = 1'b1
) (
    input  logic             tck,
    input  logic             rst,
    input  logic             update_ir,
    input  logic [OPC_W-1:0] ir_new,
    output ctl_t             ctl
);
    localparam logic [OPC_W-1:0] RESET_OP = HAS_ID ? OP_IDCODE : OP_BYPASS;

    logic [OPC_W-1:0] active_q;

    always_ff @(posedge tck) begin
        if (rst)
            active_q <= RESET_OP;
        else if (update_ir)
            active_q <= ir_new;
    end

    always_comb ctl = decode_op(active_q, HAS_ID);

    AST_RST_DEFAULT: assert property (@(posedge tck) disable iff (rst)
        $past(rst) |-> active_q == RESET_OP); // R1

    AST_ACTIVE_HOLD: assert property (@(posedge tck) disable iff (rst)
        (!$past(update_ir) && !$past(rst)) |-> $stable(active_q)); // R10

endmodule

// File: rtl/scan_bypass_reg.sv
module scan_bypass_reg (
    input  logic tck,
    input  logic rst,
    input  logic sel,
    input  logic capture,
    input  logic shift,
    input  logic tdi,
    output logic so
);
    logic byp_q;

    always_ff @(posedge tck) begin
        if (rst)
            byp_q <= 1'b0;
        else if (sel && capture)
            byp_q <= 1'b0;
        else if (sel && shift)
            byp_q <= tdi;
    end

    assign so = byp_q;

    AST_BYP_ZERO: assert property (@(posedge tck) disable iff (rst)
        (sel && capture) |=> (byp_q == 1'b0)); // R2

endmodule

// File: rtl/scan_id_reg.sv
module scan_id_reg
    import scan_dr_pkg::*;
#(
    parameter logic [3:0]  ID_VERSION = 4'h1,
    parameter logic [15:0] ID_PART    = 16'h0001,
    parameter logic [10:0] ID_MAKER   = 11'h001
) (
    input  logic            tck,
    input  logic            rst,
    input  logic            sel,
    input  logic            capture,
    input  logic            shift,
    input  logic            use_user,
    input  logic            tdi,
    input  logic [ID_W-1:0] user_code,
    output logic            so
);
    localparam logic [ID_W-1:0] FIXED_CODE = id_word(ID_VERSION, ID_PART, ID_MAKER);

    logic [ID_W-1:0] id_q;

    always_ff @(posedge tck) begin
        if (rst)
            id_q <= FIXED_CODE;
        else if (sel && capture)
            id_q <= use_user ? user_code : FIXED_CODE;
        else if (sel && shift)
            id_q <= {tdi, id_q[ID_W-1:1]};
    end

    assign so = id_q[0];

    AST_ID_LSB: assert property (@(posedge tck) disable iff (rst)
        (sel && capture && !use_user) |=> id_q[0]); // R3

    AST_ID_SHIFT: assert property (@(posedge tck) disable iff (rst)
        (sel && shift && !capture) |=> (id_q[ID_W-1] == $past(tdi))); // R11

endmodule

// File: rtl/scan_tdo_stage.sv
module scan_tdo_stage (
    input  logic tck,
    input  logic rst,
    input  logic shift_dr,
    input  logic shift_ir,
    input  logic dr_so,
    input  logic ir_so,
    output logic tdo,
    output logic tdo_en
);
    logic tdo_q;
    logic en_q;

    always_ff @(negedge tck) begin
        if (rst) begin
            tdo_q <= 1'b0;
            en_q  <= 1'b0;
        end else begin
            en_q <= shift_dr | shift_ir;
            if (shift_ir)
                tdo_q <= ir_so;
            else if (shift_dr)
                tdo_q <= dr_so;
        end
    end

    assign tdo    = tdo_q;
    assign tdo_en = en_q;

    AST_TDO_QUIET: assert property (@(negedge tck) disable iff (rst)
        (!$past(shift_dr) && !$past(shift_ir) && !$past(rst)) |-> !en_q); // R9

endmodule

// File: rtl/scan_dr_selector.sv
module scan_dr_selector
    import scan_dr_pkg::*;
#(
    parameter bit          HAS_ID     = 1'b1,
    parameter logic [3:0]  ID_VERSION = 4'h1,
    parameter logic [15:0] ID_PART    = 16'h0001,
    parameter logic [10:0] ID_MAKER   = 11'h001
) (
    input  logic             tck,
    input  logic             rst,
    input  logic             tdi,
    input  logic [OPC_W-1:0] ir_new,
    input  logic             update_ir,
    input  logic             capture_dr,
    input  logic             shift_dr,
    input  logic             shift_ir,
    input  logic             ir_so,
    input  logic             bsr_so,
    input  logic [ID_W-1:0]  user_code,
    output logic             tdo,
    output logic             tdo_en,
    output logic             bsr_capture,
    output logic             bsr_shift,
    output logic [2:0]       pin_mode,
    output logic             pin_from_bsr,
    output logic             core_from_bsr,
    output logic             pin_hiz
);
    ctl_t ctl;
    logic sel_byp;
    logic sel_id;
    logic sel_bsr;
    logic byp_so;
    logic id_so;
    logic dr_so;

    scan_ir_decode #(.HAS_ID(HAS_ID)) u_dec (
        .tck       (tck),
        .rst       (rst),
        .update_ir (update_ir),
        .ir_new    (ir_new),
        .ctl       (ctl)
    );

    assign sel_byp = (ctl.sel == DR_BYPASS);
    assign sel_id  = (ctl.sel == DR_IDENT);
    assign sel_bsr = (ctl.sel == DR_BOUNDARY);

    scan_bypass_reg u_byp (
        .tck     (tck),
        .rst     (rst),
        .sel     (sel_byp),
        .capture (capture_dr),
        .shift   (shift_dr),
        .tdi     (tdi),
        .so      (byp_so)
    );

    generate
        if (HAS_ID) begin : g_id
            scan_id_reg #(
                .ID_VERSION (ID_VERSION),
                .ID_PART    (ID_PART),
                .ID_MAKER   (ID_MAKER)
            ) u_id (
                .tck       (tck),
                .rst       (rst),
                .sel       (sel_id),
                .capture   (capture_dr),
                .shift     (shift_dr),
                .use_user  (ctl.user_id),
                .tdi       (tdi),
                .user_code (user_code),
                .so        (id_so)
            );
        end else begin : g_no_id
            assign id_so = 1'b0;
        end
    endgenerate

    always_comb begin
        case (ctl.sel)
            DR_IDENT:    dr_so = id_so;
            DR_BOUNDARY: dr_so = bsr_so;
            default:     dr_so = byp_so;
        endcase
    end

    scan_tdo_stage u_tdo (
        .tck      (tck),
        .rst      (rst),
        .shift_dr (shift_dr),
        .shift_ir (shift_ir),
        .dr_so    (dr_so),
        .ir_so    (ir_so),
        .tdo      (tdo),
        .tdo_en   (tdo_en)
    );

    assign bsr_capture   = sel_bsr & capture_dr;
    assign bsr_shift     = sel_bsr & shift_dr;
    assign pin_mode      = ctl.mode;
    assign pin_from_bsr  = (ctl.mode == MODE_EXTEST) || (ctl.mode == MODE_CLAMP);
    assign core_from_bsr = (ctl.mode == MODE_INTEST);
    assign pin_hiz       = (ctl.mode == MODE_HIGHZ);

    AST_HIZ_RELEASE: assert property (@(posedge tck) disable iff (rst)
        pin_hiz |-> (!pin_from_bsr && !sel_bsr)); // R8

endmodule

// File: tb/tb_scan_dr_selector.sv
module tb_scan_dr_selector;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0]  VER = 4'hA;
    localparam logic [15:0] PN  = 16'h3C5E;
    localparam logic [10:0] MF  = 11'h2B7;
    localparam logic [31:0] UC  = 32'h9E37_79B8;
    localparam logic [31:0] FIXED = {VER, PN, MF, 1'b1};
    localparam int NSH = 36;

    logic tck = 1'b0;
    always #(CLK_PERIOD/2) tck = ~tck;

    logic rst = 1'b1, tdi = 1'b0, update_ir = 1'b0, capture_dr = 1'b0;
    logic shift_dr = 1'b0, shift_ir = 1'b0, ir_so = 1'b0, bsr_so = 1'b0;
    logic [3:0] ir_new = 4'h0;
    logic [31:0] user_code = UC;
    logic tdo, tdo_en, bsr_capture, bsr_shift, pin_from_bsr, core_from_bsr, pin_hiz;
    logic [2:0] pin_mode;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    scan_dr_selector #(.HAS_ID(1'b1), .ID_VERSION(VER), .ID_PART(PN), .ID_MAKER(MF)) dut (
        .tck(tck), .rst(rst), .tdi(tdi), .ir_new(ir_new), .update_ir(update_ir),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .shift_ir(shift_ir),
        .ir_so(ir_so), .bsr_so(bsr_so), .user_code(user_code),
        .tdo(tdo), .tdo_en(tdo_en), .bsr_capture(bsr_capture), .bsr_shift(bsr_shift),
        .pin_mode(pin_mode), .pin_from_bsr(pin_from_bsr),
        .core_from_bsr(core_from_bsr), .pin_hiz(pin_hiz)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // 0 bypass, 1 identification, 2 boundary
    function automatic int exp_sel(input logic [3:0] op);
        if (op == 4'h0 || op == 4'h1 || op == 4'h4) return 2;
        if (op == 4'h2 || op == 4'h3) return 1;
        return 0;
    endfunction

    function automatic logic [2:0] exp_mode(input logic [3:0] op);
        case (op)
            4'h0: return 3'd1;
            4'h4: return 3'd2;
            4'h5: return 3'd3;
            4'h6: return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic pat_tdi(input int i);
        return logic'(((i * 7) % 5) < 2);
    endfunction

    function automatic logic pat_bsr(input int i);
        return logic'(((i * 3) % 4) == 1);
    endfunction

    task automatic check_modes(input logic [3:0] op, input string ctx);
        chk($sformatf("R6 pin_mode op=%0h %s", op, ctx), {29'd0, pin_mode}, {29'd0, exp_mode(op)});
        chk($sformatf("R7 pin_from_bsr op=%0h %s", op, ctx), {31'd0, pin_from_bsr},
            {31'd0, (op == 4'h0 || op == 4'h5)});
        chk($sformatf("R8 pin_hiz op=%0h %s", op, ctx), {31'd0, pin_hiz}, {31'd0, (op == 4'h6)});
        chk($sformatf("R6 core_from_bsr op=%0h %s", op, ctx), {31'd0, core_from_bsr},
            {31'd0, (op == 4'h4)});
    endtask

    task automatic load_ir(input logic [3:0] op);
        @(posedge tck); #2;
        update_ir = 1'b1; ir_new = op;
        @(posedge tck); #2;
        update_ir = 1'b0; ir_new = ~op; // R10: later changes must be ignored
        #6;
        check_modes(op, "after update");
    endtask

    task automatic scan_dr(input logic [3:0] op);
        int s;
        logic [31:0] code;
        logic e;
        s = exp_sel(op);
        code = (op == 4'h3) ? UC : FIXED;
        @(posedge tck); #2;
        capture_dr = 1'b1; shift_dr = 1'b0;
        #6;
        chk($sformatf("R9 tdo_en idle op=%0h", op), {31'd0, tdo_en}, 32'd0);
        chk($sformatf("R5 bsr_capture op=%0h", op), {31'd0, bsr_capture}, {31'd0, (s == 2)});
        for (int i = 0; i < NSH; i++) begin
            @(posedge tck); #2;
            capture_dr = 1'b0; shift_dr = 1'b1;
            tdi = pat_tdi(i); bsr_so = pat_bsr(i);
            if (i == 3) ir_new = op ^ 4'h9; // R10
            #6;
            if (s == 2) e = pat_bsr(i);
            else if (s == 1) e = (i < 32) ? code[i] : pat_tdi(i - 32);
            else e = (i == 0) ? 1'b0 : pat_tdi(i - 1);
            if (s == 2)
                chk($sformatf("R5 tdo op=%0h bit=%0d", op, i), {31'd0, tdo}, {31'd0, e});
            else if (s == 1)
                chk($sformatf("%s tdo op=%0h bit=%0d", (op == 4'h3) ? "R4" : "R3", op, i),
                    {31'd0, tdo}, {31'd0, e});
            else
                chk($sformatf("R2 tdo op=%0h bit=%0d", op, i), {31'd0, tdo}, {31'd0, e});
            if (i == 0) begin
                chk($sformatf("R9 tdo_en shift op=%0h", op), {31'd0, tdo_en}, 32'd1);
                chk($sformatf("R5 bsr_shift op=%0h", op), {31'd0, bsr_shift}, {31'd0, (s == 2)});
            end
        end
        @(posedge tck); #2;
        shift_dr = 1'b0;
        #6;
        chk($sformatf("R9 tdo_en end op=%0h", op), {31'd0, tdo_en}, 32'd0);
        check_modes(op, "R10 after scan");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge tck);
        #2; rst = 1'b0;
        #6;
        chk("R1 pin_mode after reset", {29'd0, pin_mode}, 32'd0);
        chk("R1 tdo_en after reset", {31'd0, tdo_en}, 32'd0);
        scan_dr(4'h2); // R1: reset default reads the fixed code

        for (int op = 0; op < 16; op++) begin
            load_ir(op[3:0]);
            scan_dr(op[3:0]);
        end

        // R9: IR shift path
        @(posedge tck); #2; shift_ir = 1'b1; ir_so = 1'b1; #6;
        chk("R9 tdo ir_so=1", {31'd0, tdo}, 32'd1);
        chk("R9 tdo_en shift_ir", {31'd0, tdo_en}, 32'd1);
        @(posedge tck); #2; ir_so = 1'b0; #6;
        chk("R9 tdo ir_so=0", {31'd0, tdo}, 32'd0);
        @(posedge tck); #2; shift_ir = 1'b0; #6;
        chk("R9 tdo_en after shift_ir", {31'd0, tdo_en}, 32'd0);

        // R1: mid-run reset returns to IDCODE, user code changed
        load_ir(4'h5);
        user_code = 32'h1234_5677;
        @(posedge tck); #2; rst = 1'b1;
        @(posedge tck); #2; rst = 1'b0; #6;
        chk("R1 pin_mode after second reset", {29'd0, pin_mode}, 32'd0);
        scan_dr(4'h2);

        // R4: new user code is captured
        load_ir(4'h3);
        @(posedge tck); #2; capture_dr = 1'b1; #6;
        for (int i = 0; i < 32; i++) begin
            @(posedge tck); #2; capture_dr = 1'b0; shift_dr = 1'b1; tdi = 1'b0; #6;
            chk($sformatf("R4 second user code bit=%0d", i), {31'd0, tdo}, {31'd0, user_code[i]});
        end
        @(posedge tck); #2; shift_dr = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule